// File: doc/BRIEF.md
# Picture Adjustment Stage with Field-Synchronous Settings

This block sits on the demultiplexed component path of a video encoder and makes the user's picture adjustments. Each sample carries one luma value and two chroma values. Luma is scaled by a contrast gain and then offset by a signed brightness level. Both chroma values are scaled about their 128 neutral point by one saturation gain. Every result is limited to the range 1 to 254.

Luma and chroma then pass through two separate delay lines. Each line has its own programmable depth, so that the two paths can be lined up before modulation. The valid and field-start flags travel with the luma path.

All six settings are written together through one write strobe into a holding copy. When field-synchronous update is off, the next sample uses the written set. When it is on, the written set waits until the first sample of the next field.

Top module: `color_ctrl`

## Requirements
- R1: While `rst_ni` is low and after its release, every output is 0. The active settings are then contrast 128, brightness 0, saturation 128, luma delay 0 and chroma delay 0.
- R2: The luma result is clamp(floor(y*contrast/128) + brightness, 1, 254). Contrast is unsigned 8-bit with unity at 128. Brightness is 8-bit two's complement.
- R3: Each chroma result is clamp(128 + floor((c-128)*saturation/128), 1, 254), using one unsigned 8-bit saturation gain (unity at 128) for both components.
- R4: With `dbuf_en_i` low, a set written while `wr_en_i` is high in cycle t applies to every sample presented from cycle t+1 on. This covers all six settings.
- R5: With `dbuf_en_i` high, a written set has no effect on outputs until a cycle in which `valid_i` and `field_i` are both high. That sample and all later ones use the set.
- R6: With `dbuf_en_i` high, when several writes happen before a field start, only the last one written takes effect.
- R7: A luma result appears on `y_o` 1+D cycles after its sample is presented, where D is the active luma delay (0..6). Codes 7 and above act as 6.
- R8: Chroma results appear on `cb_o`/`cr_o` 1+E cycles after presentation, where E is the active chroma delay (0..8). Codes 9 to 15 act as 8.
- R9: `valid_o` and `field_o` repeat `valid_i` and `field_i` with the same latency as luma (1+D).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample present |
| field_i | input | 1 | Sample is the first of a field |
| y_i | input | 8 | Luma in |
| cb_i | input | 8 | Blue-difference chroma in |
| cr_i | input | 8 | Red-difference chroma in |
| dbuf_en_i | input | 1 | 1: settings wait for field start |
| wr_en_i | input | 1 | Capture the setting inputs |
| contrast_i | input | 8 | Luma gain, 128 = unity |
| bright_i | input | 8 | Signed luma offset |
| sat_i | input | 8 | Chroma gain, 128 = unity |
| luma_dly_i | input | 3 | Luma delay in cycles |
| chroma_dly_i | input | 4 | Chroma delay in cycles |
| valid_o | output | 1 | Delayed valid |
| field_o | output | 1 | Delayed field start |
| y_o | output | 8 | Adjusted, delayed luma |
| cb_o | output | 8 | Adjusted, delayed blue chroma |
| cr_o | output | 8 | Adjusted, delayed red chroma |

## Verification
If the holding copy and the active copy go out of step, every sample after the expected switch point shows a wrong gain or offset. A wrongly switched delay or flag path shifts `y_o`, `valid_o` and `field_o` by whole cycles relative to inputs. Both faults appear at the first sample after the write or field start concerned, so the reference model compares every output on every clock.

// File: rtl/color_ctrl_pkg.sv
package color_ctrl_pkg;
  parameter int DW       = 8;
  parameter int GW       = 8;
  parameter int GFRAC    = 7;
  parameter int LDLY_MAX = 6;
  parameter int CDLY_MAX = 8;
  parameter int LSW      = 3;
  parameter int CSW      = 4;
  parameter int OUT_MIN  = 1;
  parameter int OUT_MAX  = 254;
  localparam int CMID    = 1 << (DW - 1);

  typedef struct packed {
    logic [GW-1:0]         contrast;
    logic signed [DW-1:0]  bright;
    logic [GW-1:0]         sat;
    logic [LSW-1:0]        ldly;
    logic [CSW-1:0]        cdly;
  } cc_cfg_t;

  localparam cc_cfg_t CFG_RESET = '{
    contrast: GW'(1 << GFRAC),
    bright:   '0,
    sat:      GW'(1 << GFRAC),
    ldly:     '0,
    cdly:     '0
  };
endpackage

// File: rtl/cc_cfg_regs.sv
module cc_cfg_regs
  import color_ctrl_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    wr_en_i,
  input  cc_cfg_t wr_cfg_i,
  input  logic    dbuf_en_i,
  input  logic    sof_i,
  output cc_cfg_t eff_o,
  output cc_cfg_t act_o,
  output cc_cfg_t shd_o
);
  cc_cfg_t shd_q, act_q;
  logic    load;

  assign load  = !dbuf_en_i || sof_i;
  assign eff_o = load ? shd_q : act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shd_q <= CFG_RESET;
      act_q <= CFG_RESET;
    end else begin
      act_q <= eff_o;
      if (wr_en_i) shd_q <= wr_cfg_i;
    end
  end

  assign act_o = act_q;
  assign shd_o = shd_q;
endmodule

// File: rtl/cc_luma_scale.sv
module cc_luma_scale
  import color_ctrl_pkg::*;
(
  input  logic [DW-1:0]        y_i,
  input  logic [GW-1:0]        gain_i,
  input  logic signed [DW-1:0] offs_i,
  output logic [DW-1:0]        y_o
);
  localparam int PW = DW + GW;
  localparam int SW = PW + 2;
  logic [PW-1:0]        prod;
  logic signed [SW-1:0] sum;

  always_comb begin
    prod = PW'(y_i) * PW'(gain_i);
    sum  = $signed(SW'(prod >> GFRAC)) + SW'(offs_i);
    if (sum < SW'(OUT_MIN))      y_o = DW'(OUT_MIN);
    else if (sum > SW'(OUT_MAX)) y_o = DW'(OUT_MAX);
    else                         y_o = sum[DW-1:0];
  end
endmodule

// File: rtl/cc_chroma_scale.sv
module cc_chroma_scale
  import color_ctrl_pkg::*;
(
  input  logic [DW-1:0] c_i,
  input  logic [GW-1:0] gain_i,
  output logic [DW-1:0] c_o
);
  localparam int PW = DW + GW + 2;
  logic signed [PW-1:0] diff, gain, prod, res;

  always_comb begin
    diff = $signed(PW'(c_i)) - PW'(CMID);
    gain = $signed(PW'(gain_i));
    prod = diff * gain;
    res  = (prod >>> GFRAC) + PW'(CMID);
    if (res < PW'(OUT_MIN))      c_o = DW'(OUT_MIN);
    else if (res > PW'(OUT_MAX)) c_o = DW'(OUT_MAX);
    else                         c_o = res[DW-1:0];
  end
endmodule

// File: rtl/cc_tap_delay.sv
module cc_tap_delay #(
  parameter int W    = 8,
  parameter int MAXD = 6,
  parameter int SW   = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [W-1:0]  d_i,
  input  logic [SW-1:0] sel_i,
  output logic [W-1:0]  q_o
);
  localparam logic [SW-1:0] SEL_MAX = SW'(MAXD);
  logic [W-1:0]  stg [MAXD+1];
  logic [SW-1:0] sel_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg[0] <= '0;
    else         stg[0] <= d_i;
  end

  for (genvar i = 1; i <= MAXD; i++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg[i] <= '0;
      else         stg[i] <= stg[i-1];
    end
  end

  assign sel_c = (sel_i > SEL_MAX) ? SEL_MAX : sel_i;
  assign q_o   = stg[sel_c];
endmodule

// File: rtl/color_ctrl.sv
module color_ctrl
  import color_ctrl_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic                 field_i,
  input  logic [DW-1:0]        y_i,
  input  logic [DW-1:0]        cb_i,
  input  logic [DW-1:0]        cr_i,
  input  logic                 dbuf_en_i,
  input  logic                 wr_en_i,
  input  logic [GW-1:0]        contrast_i,
  input  logic signed [DW-1:0] bright_i,
  input  logic [GW-1:0]        sat_i,
  input  logic [LSW-1:0]       luma_dly_i,
  input  logic [CSW-1:0]       chroma_dly_i,
  output logic                 valid_o,
  output logic                 field_o,
  output logic [DW-1:0]        y_o,
  output logic [DW-1:0]        cb_o,
  output logic [DW-1:0]        cr_o
);
  localparam int LW = DW + 2;
  localparam int CW = 2 * DW;

  cc_cfg_t wr_cfg, eff_cfg, act_cfg, shd_cfg;
  logic [DW-1:0] y_adj;
  logic [DW-1:0] c_in  [2];
  logic [DW-1:0] c_adj [2];
  logic [LW-1:0] luma_q;
  logic [CW-1:0] chroma_q;

  assign wr_cfg = '{contrast: contrast_i, bright: bright_i, sat: sat_i,
                    ldly: luma_dly_i, cdly: chroma_dly_i};

  cc_cfg_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_cfg_i  (wr_cfg),
    .dbuf_en_i (dbuf_en_i),
    .sof_i     (valid_i && field_i),
    .eff_o     (eff_cfg),
    .act_o     (act_cfg),
    .shd_o     (shd_cfg)
  );

  cc_luma_scale u_luma (
    .y_i    (y_i),
    .gain_i (eff_cfg.contrast),
    .offs_i (eff_cfg.bright),
    .y_o    (y_adj)
  );

  assign c_in[0] = cb_i;
  assign c_in[1] = cr_i;

  for (genvar k = 0; k < 2; k++) begin : g_chroma
    cc_chroma_scale u_sc (
      .c_i    (c_in[k]),
      .gain_i (eff_cfg.sat),
      .c_o    (c_adj[k])
    );
  end

  cc_tap_delay #(.W(LW), .MAXD(LDLY_MAX), .SW(LSW)) u_ldly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({valid_i, field_i, y_adj}),
    .sel_i  (act_cfg.ldly),
    .q_o    (luma_q)
  );

  cc_tap_delay #(.W(CW), .MAXD(CDLY_MAX), .SW(CSW)) u_cdly (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({c_adj[1], c_adj[0]}),
    .sel_i  (act_cfg.cdly),
    .q_o    (chroma_q)
  );

  assign {valid_o, field_o, y_o} = luma_q;
  assign {cr_o, cb_o}            = chroma_q;
endmodule

// File: rtl/color_ctrl_chk.sv
module color_ctrl_chk
  import color_ctrl_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          valid_i,
  input logic          field_i,
  input logic          dbuf_en_i,
  input logic          valid_o,
  input logic [DW-1:0] y_o,
  input cc_cfg_t       act_cfg,
  input cc_cfg_t       shd_cfg
);
  AST_LUMA_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (y_o >= DW'(OUT_MIN) && y_o <= DW'(OUT_MAX))); // R2

  AST_DIRECT_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dbuf_en_i |=> act_cfg == $past(shd_cfg)); // R4

  AST_FIELD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dbuf_en_i && !(valid_i && field_i)) |=> $stable(act_cfg)); // R5

  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dbuf_en_i && !field_i && act_cfg.ldly == '0) |=> valid_o); // R9
endmodule

bind color_ctrl color_ctrl_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .valid_i   (valid_i),
  .field_i   (field_i),
  .dbuf_en_i (dbuf_en_i),
  .valid_o   (valid_o),
  .y_o       (y_o),
  .act_cfg   (act_cfg),
  .shd_cfg   (shd_cfg)
);

// File: tb/color_ctrl_bench.sv
module color_ctrl_bench;
  logic clk = 0;
  logic rst_n = 0;
  logic valid = 0, field = 0, dbuf = 0, wr = 0;
  logic [7:0] y = 0, cb = 0, cr = 0, con = 128, sat = 128;
  logic signed [7:0] bri = 0;
  logic [2:0] ldly = 0;
  logic [3:0] cdly = 0;
  logic valid_o, field_o;
  logic [7:0] y_o, cb_o, cr_o;

  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  color_ctrl u_color_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .field_i(field),
    .y_i(y), .cb_i(cb), .cr_i(cr), .dbuf_en_i(dbuf), .wr_en_i(wr),
    .contrast_i(con), .bright_i(bri), .sat_i(sat),
    .luma_dly_i(ldly), .chroma_dly_i(cdly),
    .valid_o(valid_o), .field_o(field_o), .y_o(y_o), .cb_o(cb_o), .cr_o(cr_o)
  );

  // reference model: settings as integers, output history as arrays
  int a_con, a_bri, a_sat, a_ld, a_cd;
  int s_con, s_bri, s_sat, s_ld, s_cd;
  int hy[16], hv[16], hf[16], hb[16], hr[16];

  function automatic int clampv(int v);
    return (v < 1) ? 1 : (v > 254) ? 254 : v;
  endfunction

  function automatic int chroma_ref(int c, int g);
    int d;
    d = (c - 128) * g;
    return clampv(128 + (d >>> 7));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_con = 128; a_bri = 0; a_sat = 128; a_ld = 0; a_cd = 0;
      s_con = 128; s_bri = 0; s_sat = 128; s_ld = 0; s_cd = 0;
      for (int i = 0; i < 16; i++) begin
        hy[i] = 0; hv[i] = 0; hf[i] = 0; hb[i] = 0; hr[i] = 0;
      end
    end else begin
      if (!dbuf || (valid && field)) begin
        a_con = s_con; a_bri = s_bri; a_sat = s_sat; a_ld = s_ld; a_cd = s_cd;
      end
      for (int i = 15; i > 0; i--) begin
        hy[i] = hy[i-1]; hv[i] = hv[i-1]; hf[i] = hf[i-1];
        hb[i] = hb[i-1]; hr[i] = hr[i-1];
      end
      hy[0] = clampv(((int'(y) * a_con) >>> 7) + a_bri);
      hb[0] = chroma_ref(int'(cb), a_sat);
      hr[0] = chroma_ref(int'(cr), a_sat);
      hv[0] = int'(valid);
      hf[0] = int'(field);
      if (wr) begin
        s_con = int'(con); s_bri = int'(bri); s_sat = int'(sat);
        s_ld = int'(ldly); s_cd = int'(cdly);
      end
    end
  end

  task automatic chk(string what, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", cur_req, what, act, exp, $time);
    end
  endtask

  // per-cycle compare away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      automatic int d = (a_ld > 6) ? 6 : a_ld;
      automatic int e = (a_cd > 8) ? 8 : a_cd;
      chk("y_o", int'(y_o), hy[d]);
      chk("valid_o", int'(valid_o), hv[d]);
      chk("field_o", int'(field_o), hf[d]);
      chk("cb_o", int'(cb_o), hb[e]);
      chk("cr_o", int'(cr_o), hr[e]);
    end
  end

  task automatic put_cfg(int c, int b, int s, int l, int cd);
    @(negedge clk);
    wr = 1; con = 8'(c); bri = 8'(b); sat = 8'(s); ldly = 3'(l); cdly = 4'(cd);
    @(negedge clk);
    wr = 0;
  endtask

  task automatic run(int n, int fs_every);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = ($urandom_range(0, 3) != 0);
      field = (fs_every > 0) && valid && (($urandom_range(0, fs_every - 1)) == 0);
      y = 8'($urandom); cb = 8'($urandom); cr = 8'($urandom);
    end
  endtask

  task automatic quiet(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1; field = 0;
      y = 8'($urandom); cb = 8'($urandom); cr = 8'($urandom);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    cur_req = "R1";
    chk("y_o in reset", int'(y_o), 0);
    chk("valid_o in reset", int'(valid_o), 0);
    chk("cb_o in reset", int'(cb_o), 0);
    rst_n = 1;
    // R1 R2 R3: unity settings, clamp of codes 0 and 255
    run(40, 0);
    @(negedge clk); y = 0; cb = 255; cr = 0; valid = 1;
    @(negedge clk); y = 255; cb = 0; cr = 255;
    // R4: direct update from next sample
    cur_req = "R4";
    put_cfg(200, -20, 64, 2, 3);
    run(40, 0);
    // R2 extremes
    cur_req = "R2";
    put_cfg(255, 127, 128, 0, 0);
    run(20, 0);
    put_cfg(0, -128, 128, 0, 0);
    run(20, 0);
    put_cfg(100, 30, 128, 1, 1);
    run(20, 0);
    // R3 extremes
    cur_req = "R3";
    put_cfg(128, 0, 255, 0, 0);
    run(20, 0);
    put_cfg(128, 0, 0, 0, 0);
    run(20, 0);
    // R7 R8 R9: delay sweep, including clamped codes
    for (int l = 0; l < 8; l++) begin
      cur_req = "R7";
      put_cfg(150, 5, 90, l, 2 * l);
      run(20, 4);
    end
    for (int c = 8; c < 16; c++) begin
      cur_req = "R8";
      put_cfg(128, 0, 200, 6, c);
      run(20, 4);
    end
    // R5: held until a valid field start
    cur_req = "R5";
    @(negedge clk); dbuf = 1;
    put_cfg(60, 40, 30, 4, 7);
    quiet(20);
    @(negedge clk); valid = 0; field = 1;   // field flag without valid: no switch
    quiet(10);
    @(negedge clk); valid = 1; field = 1;
    quiet(20);
    // R6: only the last write before the field start counts
    cur_req = "R6";
    put_cfg(220, -50, 250, 1, 0);
    quiet(5);
    put_cfg(90, 12, 170, 5, 8);
    quiet(10);
    @(negedge clk); valid = 1; field = 1;
    quiet(20);
    cur_req = "R5";
    run(200, 16);
    @(negedge clk); dbuf = 0;
    cur_req = "R9";
    run(60, 3);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule